// File: doc/BRIEF.md
# Adder-Based Multi-Function ALU

This block is a purely combinational arithmetic logic unit whose every arithmetic and bitwise result comes from one row of adder bit cells. Each cell produces a propagate term (the XOR of its two inputs) and a generate term (their AND). The carry chain either ripples through these cells or is forced to zero. With the chain running, the row performs addition. With operand A inverted and a carry of one injected at the bottom, it performs reverse subtraction (B minus A). With the chain held at zero, the sum outputs give XOR and the generate terms give AND. Inversion of A and one-place shifts of B are picked up from the same operand wires.

A small decoder turns the 4-bit operation code into a bundle of strobes. The strobes drive the datapath: operand inversion, carry injection, carry squash, which result source is selected, and whether the carry-out is meaningful. The operand width is a parameter. The result and carry-out settle in the same cycle as the inputs, so the block sits directly between registers in a larger datapath.

Top module: `adder_alu`

## Requirements
- R1: Operation code 0000 gives result = (A + B + carryIn) mod 2^N, and carryOut equals bit N of that sum.
- R2: Operation code 0010 gives result = (B − A) mod 2^N, computed as B + ~A + 1. carryOut is 1 exactly when B ≥ A (unsigned), and carryIn has no effect.
- R3: Operation code 0100 gives result = A XOR B, taken from the adder sum outputs with the carry chain held at zero.
- R4: Operation code 1000 gives result = A AND B.
- R5: Operation code 0001 gives result = bitwise inverse of A.
- R6: Operation code 1110 gives result = B shifted left by one bit, with bit 0 filled with 0.
- R7: Operation code 1100 gives result = B shifted right by one bit (logical), with bit N−1 filled with 0.
- R8: carryOut is 0 for every operation code other than 0000 and 0010.
- R9: Every operation code not listed in R1–R7 gives result 0 and carryOut 0.
- R10: carryIn has no effect on either output for any operation code other than 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | N | First operand (A) |
| opB | input | N | Second operand (B) |
| carryIn | input | 1 | Incoming carry, used by addition only |
| opCode | input | 4 | Operation select |
| result | output | N | Operation result |
| carryOut | output | 1 | Carry out of the adder for add/subtract, else 0 |

## Verification
Addition and subtraction are driven with all-zero operands, all-ones operands, and alternating-bit operands. These patterns separate a correct ripple chain from a stuck or squashed carry: all-ones plus one with carry-in must wrap to zero with carry-out set, and equal operands under subtraction must yield zero with carry-out set. Pseudo-random operand pairs are swept across all sixteen operation codes, each with carry-in both 0 and 1. This exposes any leakage of carry-in into the bitwise, shift or undefined codes, and any mix-up between B minus A and A minus B. Single-bit operands at the MSB and LSB show whether the shift fills and directions are right.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD = 4'b0000,
    OP_INV = 4'b0001,
    OP_SUB = 4'b0010,
    OP_XOR = 4'b0100,
    OP_AND = 4'b1000,
    OP_SHR = 4'b1100,
    OP_SHL = 4'b1110
  } aluOp_e;

  typedef struct packed {
    logic invA;        // feed ~A into the adder row
    logic forceCin;    // inject a carry of 1 at bit 0
    logic killCarry;   // hold the whole carry chain at zero
    logic enSum;       // result from adder sum outputs
    logic enGen;       // result from generate terms (A AND B)
    logic enInv;       // result is ~A
    logic enShl;       // result is B << 1
    logic enShr;       // result is B >> 1
    logic carryValid;  // carry-out is meaningful
  } aluCtrl_t;

  localparam aluCtrl_t CTRL_IDLE = '{default: 1'b0};

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [3:0] opCode,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl = CTRL_IDLE;
    case (opCode)
      OP_ADD: begin
        ctrl.enSum      = 1'b1;
        ctrl.carryValid = 1'b1;
      end
      OP_SUB: begin
        ctrl.invA       = 1'b1;
        ctrl.forceCin   = 1'b1;
        ctrl.enSum      = 1'b1;
        ctrl.carryValid = 1'b1;
      end
      OP_XOR: begin
        ctrl.killCarry = 1'b1;
        ctrl.enSum     = 1'b1;
      end
      OP_AND: begin
        ctrl.killCarry = 1'b1;
        ctrl.enGen     = 1'b1;
      end
      OP_INV: begin
        ctrl.killCarry = 1'b1;
        ctrl.enInv     = 1'b1;
      end
      OP_SHL: begin
        ctrl.killCarry = 1'b1;
        ctrl.enShl     = 1'b1;
      end
      OP_SHR: begin
        ctrl.killCarry = 1'b1;
        ctrl.enShr     = 1'b1;
      end
      default: ctrl = CTRL_IDLE;
    endcase
  end

  // R9: at most one result source is ever selected
  always_comb begin
    p_one_source_r9: assert ($onehot0({ctrl.enSum, ctrl.enGen, ctrl.enInv,
                                       ctrl.enShl, ctrl.enShr}))
      else $error("more than one result source selected");
  end

  // R8: carry reported only when the chain is live
  always_comb begin
    p_carry_live_r8: assert (!(ctrl.carryValid && ctrl.killCarry))
      else $error("carry reported while chain squashed");
  end

endmodule

// File: rtl/alu_bitcell.sv
module alu_bitcell (
  input  logic aBit,
  input  logic bBit,
  input  logic cIn,
  input  logic killCarry,
  output logic prop,
  output logic gen,
  output logic sum,
  output logic cOut
);

  assign prop = aBit ^ bBit;
  assign gen  = aBit & bBit;
  assign sum  = prop ^ cIn;
  assign cOut = ~killCarry & (gen | (prop & cIn));

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  input  aluCtrl_t     ctrl,
  output logic [N-1:0] result,
  output logic         carryOut
);

  localparam int MSB = N - 1;

  logic [N-1:0] aEff;
  logic [N:0]   carry;
  logic [N-1:0] propV, genV, sumV;

  assign aEff     = ctrl.invA ? ~opA : opA;
  assign carry[0] = ctrl.killCarry ? 1'b0 : (ctrl.forceCin ? 1'b1 : carryIn);

  for (genvar i = 0; i < N; i++) begin : g_row
    alu_bitcell u_cell (
      .aBit     (aEff[i]),
      .bBit     (opB[i]),
      .cIn      (carry[i]),
      .killCarry(ctrl.killCarry),
      .prop     (propV[i]),
      .gen      (genV[i]),
      .sum      (sumV[i]),
      .cOut     (carry[i+1])
    );
  end

  always_comb begin
    result = '0;
    if (ctrl.enSum) result = sumV;
    if (ctrl.enGen) result = genV;
    if (ctrl.enInv) result = ~opA;
    if (ctrl.enShl) result = {opB[MSB-1:0], 1'b0};
    if (ctrl.enShr) result = {1'b0, opB[MSB:1]};
  end

  assign carryOut = ctrl.carryValid ? carry[N] : 1'b0;

  // R3: a squashed chain never produces a carry at the top
  always_comb begin
    p_chain_squashed_r3: assert (!ctrl.killCarry || (carry[N] == 1'b0))
      else $error("carry escaped a squashed chain");
  end

  // R3: with the chain squashed the sum outputs equal the propagate terms
  always_comb begin
    p_sum_is_prop_r3: assert (!ctrl.killCarry || (sumV == propV))
      else $error("sum differs from propagate while squashed");
  end

endmodule

// File: rtl/adder_alu.sv
module adder_alu
  import alu_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] opA,
  input  logic [N-1:0] opB,
  input  logic         carryIn,
  input  logic [3:0]   opCode,
  output logic [N-1:0] result,
  output logic         carryOut
);

  aluCtrl_t ctrl;

  alu_ctrl u_ctrl (
    .opCode(opCode),
    .ctrl  (ctrl)
  );

  alu_datapath #(.N(N)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .ctrl    (ctrl),
    .result  (result),
    .carryOut(carryOut)
  );

  logic isArith, isDefined;
  assign isArith   = (opCode == OP_ADD) || (opCode == OP_SUB);
  assign isDefined = isArith || (opCode == OP_XOR) || (opCode == OP_AND) ||
                     (opCode == OP_INV) || (opCode == OP_SHL) || (opCode == OP_SHR);

  // R8
  always_comb begin
    p_cout_quiet_r8: assert (isArith || (carryOut == 1'b0))
      else $error("carry-out set on a non-arithmetic code");
  end

  // R9
  always_comb begin
    p_undef_zero_r9: assert (isDefined || (result == '0))
      else $error("undefined code produced a nonzero result");
  end

  // R6
  always_comb begin
    p_shl_fill_r6: assert ((opCode != OP_SHL) || (result[0] == 1'b0))
      else $error("left shift did not fill bit 0 with zero");
  end

  // R7
  always_comb begin
    p_shr_fill_r7: assert ((opCode != OP_SHR) || (result[N-1] == 1'b0))
      else $error("right shift did not fill the top bit with zero");
  end

endmodule

// File: tb/test_adder_alu.sv
module test_adder_alu;

  localparam int N = 8;
  localparam longint MASK = (64'd1 << N) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [N-1:0] opA = '0, opB = '0;
  logic carryIn = 1'b0;
  logic [3:0] opCode = 4'b0000;
  logic [N-1:0] result;
  logic carryOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  adder_alu #(.N(N)) i_adder_alu (
    .opA(opA), .opB(opB), .carryIn(carryIn), .opCode(opCode),
    .result(result), .carryOut(carryOut)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'b0000: return "R1";
      4'b0010: return "R2";
      4'b0100: return "R3";
      4'b1000: return "R4";
      4'b0001: return "R5";
      4'b1110: return "R6";
      4'b1100: return "R7";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference: returns {carry, result}
  function automatic longint model(input longint a, input longint b,
                                   input logic ci, input logic [3:0] op);
    longint r;
    case (op)
      4'b0000: r = a + b + longint'(ci);
      4'b0010: r = b + ((~a) & MASK) + 1;
      4'b0100: r = a ^ b;
      4'b1000: r = a & b;
      4'b0001: r = (~a) & MASK;
      4'b1110: r = (b << 1) & MASK;
      4'b1100: r = b >> 1;
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic checkOne(input string tag, input string what,
                          input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s op=%b a=%0h b=%0h ci=%0b actual=%0h expected=%0h",
               tag, what, opCode, opA, opB, carryIn, act, exp);
    end
  endtask

  // drive after the rising edge, compare at the falling edge
  task automatic apply(input longint a, input longint b, input logic ci,
                       input logic [3:0] op);
    longint exp, alt;
    @(posedge clk);
    #1;
    opA = a[N-1:0]; opB = b[N-1:0]; carryIn = ci; opCode = op;
    @(negedge clk);
    exp = model(a & MASK, b & MASK, ci, op);
    checkOne(tagOf(op), "result", longint'(result), exp & MASK);
    checkOne((op == 4'b0000 || op == 4'b0010) ? tagOf(op) : "R8", "carry",
             longint'(carryOut), (exp >> N) & 1);
    if (op != 4'b0000 && ci) begin
      alt = model(a & MASK, b & MASK, 1'b0, op);
      checkOne("R10", "result-vs-cin0", longint'(result), alt & MASK);
      checkOne("R10", "carry-vs-cin0", longint'(carryOut), (alt >> N) & 1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // reset state: zero operands, add, no carry
    @(negedge clk);
    checkOne("R1", "reset-result", longint'(result), 0);
    checkOne("R1", "reset-carry", longint'(carryOut), 0);

    // R1 corners
    apply(MASK, 1, 0, 4'b0000);
    apply(MASK, 0, 1, 4'b0000);
    apply(MASK, MASK, 1, 4'b0000);
    apply(8'h55, 8'hAA, 0, 4'b0000);
    apply(8'h55, 8'hAA, 1, 4'b0000);
    // R2 corners: equal, B<A, B>A, cin ignored
    apply(8'h3C, 8'h3C, 0, 4'b0010);
    apply(8'h01, 8'h00, 1, 4'b0010);
    apply(8'h00, 8'hFF, 0, 4'b0010);
    apply(8'h10, 8'h05, 1, 4'b0010);
    // R3/R4/R5 patterns
    apply(8'hFF, 8'hFF, 1, 4'b0100);
    apply(8'h55, 8'hAA, 0, 4'b1000);
    apply(8'hF0, 8'h3C, 1, 4'b1000);
    apply(8'h00, 8'hFF, 1, 4'b0001);
    // R6/R7 boundary bits
    apply(0, 8'h80, 1, 4'b1110);
    apply(0, 8'h01, 0, 4'b1110);
    apply(0, 8'h01, 1, 4'b1100);
    apply(0, 8'h80, 0, 4'b1100);
    // R9: every code with full operands and carry in
    for (int op = 0; op < 16; op++) apply(MASK, MASK, 1, 4'(op));
    // sweep all codes with pseudo-random operands
    for (int k = 0; k < 200; k++) begin
      for (int op = 0; op < 16; op++) begin
        apply(longint'($urandom), longint'($urandom), 1'($urandom), 4'(op));
      end
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule